// File: doc/BRIEF.md
# Bad-Block Mark Swapper

This block exchanges one byte of a page data buffer with the first byte of the page's spare-area (auxiliary) buffer. The data byte does not need to be byte-aligned. It starts at a byte address and a bit position inside that byte, and so it can span two neighbouring bytes of the page RAM. The block keeps the auxiliary first byte in its own register. It reaches the page RAM through one read strobe and one write strobe, and it runs one complete exchange for each accepted start request.

The exchange is its own inverse. The same operation therefore runs before an encoder writes a page and after a decoder reads it back. In the first case it moves the factory bad-block marker out of the data area, and in the second case it puts the marker back. Running it twice with the same offsets restores both the RAM and the register.

The offsets come from outside the block, and so does the page RAM. The RAM must return read data exactly one cycle after a read strobe.

Top module: `badmark_swap`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `busy`, `done`, `ram_rd_en` and `ram_wr_en` are low and `aux_byte` is 0x00.
- R2: When idle, a high `aux_wr_en` loads `aux_wr_data` into `aux_byte`, which shows the new value from the next cycle on.
- R3: After an exchange at byte address b and bit position k, `aux_byte` equals bits [k+7:k] of the 16-bit word {data[b+1], data[b]}, taken before the exchange.
- R4: After an exchange, data[b] keeps its bits below k, and its bits k to 7 hold bits 0 to 7−k of the previous `aux_byte`.
- R5: After an exchange, data[b+1] keeps its bits k to 7, and its bits below k hold bits 8−k to 7 of the previous `aux_byte`. With k = 0, data[b+1] is written back unchanged.
- R6: Two exchanges with the same b and k restore data[b], data[b+1] and `aux_byte` to their values before the first exchange.
- R7: A start request is accepted at the clock edge where `start` is high and `busy` is low. The cycles that follow are, in order: read of b, read of b+1, write of b, write of b+1, update of `aux_byte`, and a one-cycle `done`. As a result, `done` is sampled high in the sixth cycle after the accepting edge.
- R8: An exchange writes only addresses b and b+1. The address b+1 wraps modulo 2^ADDR_W, so b = 255 pairs with address 0 at the default width.
- R9: A `start` that arrives while `busy` is high is ignored. It changes neither the exchange in progress nor any RAM byte, and it does not queue a second exchange.
- R10: An `aux_wr_en` that arrives while `busy` is high is ignored.
- R11: `busy` is high from the cycle after the accepting edge up to and including the `done` cycle, and it is low in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one exchange |
| byte_ofs | input | ADDR_W | Byte address b of the first data byte |
| bit_ofs | input | 3 | Bit position k inside byte b |
| aux_wr_en | input | 1 | Load the auxiliary byte (honoured only when idle) |
| aux_wr_data | input | 8 | Value loaded into the auxiliary byte |
| aux_byte | output | 8 | Current auxiliary first byte |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle pulse at the end of an exchange |
| ram_rd_en | output | 1 | Page RAM read strobe |
| ram_rd_addr | output | ADDR_W | Page RAM read address |
| ram_rd_data | input | 8 | Page RAM read data, one cycle after the strobe |
| ram_wr_en | output | 1 | Page RAM write strobe |
| ram_wr_addr | output | ADDR_W | Page RAM write address |
| ram_wr_data | output | 8 | Page RAM write data |

## Verification
The properties assume that the RAM returns read data exactly one cycle after the strobe. They also assume that nothing else writes the RAM while `busy` is high. The bench RAM model is registered with a fixed one-cycle read and is the only agent on the RAM ports. The bench changes its backing store only between exchanges.

The sweep covers every bit position against several data and auxiliary patterns, a wrapping pair of addresses, and back-to-back exchanges. It also drives `start` and `aux_wr_en` during an exchange, so that the checks on ignored inputs see a real conflict.

// File: rtl/badmark_swap_pkg.sv
package badmark_swap_pkg;

    localparam int BYTE_W  = 8;
    localparam int SHIFT_W = 3;

    // Exchange sequence, one state per cycle
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_LO,
        ST_RD_HI,
        ST_WR_LO,
        ST_WR_HI,
        ST_UPD,
        ST_FIN
    } bm_state_e;

    // Results of the merge network
    typedef struct packed {
        logic [BYTE_W-1:0] src;
        logic [BYTE_W-1:0] new_lo;
        logic [BYTE_W-1:0] new_hi;
    } bm_merge_t;

    // Mask of the bits below position k
    function automatic logic [BYTE_W-1:0] below_mask(input logic [SHIFT_W-1:0] k);
        logic [BYTE_W:0] one_hot;
        one_hot = (BYTE_W+1)'(1) << k;
        return BYTE_W'(one_hot - (BYTE_W+1)'(1));
    endfunction

endpackage

// File: rtl/badmark_swap_merge.sv
module badmark_swap_merge
    import badmark_swap_pkg::*;
(
    input  logic [BYTE_W-1:0]  lo,
    input  logic [BYTE_W-1:0]  hi,
    input  logic [BYTE_W-1:0]  aux,
    input  logic [SHIFT_W-1:0] k,
    output bm_merge_t          res
);
    localparam int PAIR_W = 2 * BYTE_W;

    logic [PAIR_W-1:0] pair_in;
    logic [PAIR_W-1:0] pair_shr;
    logic [PAIR_W-1:0] aux_spread;
    logic [BYTE_W-1:0] keep;

    always_comb begin
        pair_in    = {hi, lo};
        pair_shr   = pair_in >> k;
        aux_spread = PAIR_W'(aux) << k;
        keep       = below_mask(k);

        res.src    = pair_shr[BYTE_W-1:0];
        res.new_lo = (lo & keep)  | aux_spread[BYTE_W-1:0];
        res.new_hi = (hi & ~keep) | aux_spread[PAIR_W-1:BYTE_W];
    end

endmodule

// File: rtl/badmark_swap_ctrl.sv
module badmark_swap_ctrl
    import badmark_swap_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    output logic      accept,
    output bm_state_e state
);
    bm_state_e nxt;

    assign accept = start && (state == ST_IDLE);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = ST_RD_LO;
            ST_RD_LO: nxt = ST_RD_HI;
            ST_RD_HI: nxt = ST_WR_LO;
            ST_WR_LO: nxt = ST_WR_HI;
            ST_WR_HI: nxt = ST_UPD;
            ST_UPD:   nxt = ST_FIN;
            ST_FIN:   nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

endmodule

// File: rtl/badmark_swap_auxreg.sv
module badmark_swap_auxreg
    import badmark_swap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [BYTE_W-1:0] load_data,
    input  logic              upd_en,
    input  logic [BYTE_W-1:0] upd_data,
    output logic [BYTE_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)          q <= '0;
        else if (upd_en)  q <= upd_data;
        else if (load_en) q <= load_data;
    end

endmodule

// File: rtl/badmark_swap.sv
module badmark_swap
    import badmark_swap_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] byte_ofs,
    input  logic [2:0]        bit_ofs,
    input  logic              aux_wr_en,
    input  logic [7:0]        aux_wr_data,
    output logic [7:0]        aux_byte,
    output logic              busy,
    output logic              done,
    output logic              ram_rd_en,
    output logic [ADDR_W-1:0] ram_rd_addr,
    input  logic [7:0]        ram_rd_data,
    output logic              ram_wr_en,
    output logic [ADDR_W-1:0] ram_wr_addr,
    output logic [7:0]        ram_wr_data
);
    bm_state_e          state;
    logic               accept;
    logic [ADDR_W-1:0]  base_q;
    logic [ADDR_W-1:0]  next_addr;
    logic [SHIFT_W-1:0] shift_q;
    logic [BYTE_W-1:0]  lo_q;
    logic [BYTE_W-1:0]  hi_q;
    bm_merge_t          mres;

    badmark_swap_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .accept (accept),
        .state  (state)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            shift_q <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
        end else begin
            if (accept) begin
                base_q  <= byte_ofs;
                shift_q <= bit_ofs;
            end
            if (state == ST_RD_HI) lo_q <= ram_rd_data;
            if (state == ST_WR_LO) hi_q <= ram_rd_data;
        end
    end

    assign next_addr = base_q + ADDR_W'(1);

    badmark_swap_merge u_merge (
        .lo  (lo_q),
        .hi  (hi_q),
        .aux (aux_byte),
        .k   (shift_q),
        .res (mres)
    );

    badmark_swap_auxreg u_aux (
        .clk       (clk),
        .rst       (rst),
        .load_en   (aux_wr_en && (state == ST_IDLE)),
        .load_data (aux_wr_data),
        .upd_en    (state == ST_UPD),
        .upd_data  (mres.src),
        .q         (aux_byte)
    );

    always_comb begin
        ram_rd_en   = (state == ST_RD_LO) || (state == ST_RD_HI);
        ram_rd_addr = (state == ST_RD_HI) ? next_addr : base_q;
        ram_wr_en   = (state == ST_WR_LO) || (state == ST_WR_HI);
        ram_wr_addr = (state == ST_WR_HI) ? next_addr : base_q;
        ram_wr_data = (state == ST_WR_HI) ? mres.new_hi : mres.new_lo;
        busy        = (state != ST_IDLE);
        done        = (state == ST_FIN);
    end

endmodule

// File: rtl/badmark_swap_chk.sv
module badmark_swap_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [ADDR_W-1:0] byte_ofs,
    input logic              aux_wr_en,
    input logic [7:0]        aux_byte,
    input logic              busy,
    input logic              done,
    input logic              ram_rd_en,
    input logic [ADDR_W-1:0] ram_rd_addr,
    input logic              ram_wr_en,
    input logic [ADDR_W-1:0] ram_wr_addr
);
    // R7
    accept_reads_base_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (ram_rd_en && ram_rd_addr == $past(byte_ofs)));

    // R7
    no_rd_wr_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ram_rd_en, ram_wr_en}));

    // R8
    second_write_next_chk: assert property (@(posedge clk) disable iff (rst)
        (ram_wr_en && $past(ram_wr_en)) |-> (ram_wr_addr == $past(ram_wr_addr) + ADDR_W'(1)));

    // R8
    write_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (ram_wr_en || ram_rd_en) |-> busy);

    // R10
    aux_change_source_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(aux_byte) |-> (done || ($past(aux_wr_en) && !$past(busy))));

    // R11
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    // R11
    done_inside_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

endmodule

bind badmark_swap badmark_swap_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .byte_ofs    (byte_ofs),
    .aux_wr_en   (aux_wr_en),
    .aux_byte    (aux_byte),
    .busy        (busy),
    .done        (done),
    .ram_rd_en   (ram_rd_en),
    .ram_rd_addr (ram_rd_addr),
    .ram_wr_en   (ram_wr_en),
    .ram_wr_addr (ram_wr_addr)
);

// File: tb/test_badmark_swap.sv
`timescale 1ns/1ps
module test_badmark_swap;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] byte_ofs = '0;
    logic [2:0]    bit_ofs = '0;
    logic          aux_wr_en = 1'b0;
    logic [7:0]    aux_wr_data = '0;
    logic [7:0]    aux_byte;
    logic          busy, done;
    logic          ram_rd_en, ram_wr_en;
    logic [AW-1:0] ram_rd_addr, ram_wr_addr;
    logic [7:0]    ram_rd_data, ram_wr_data;

    logic [7:0] mem [256];
    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (ram_wr_en) mem[ram_wr_addr] <= ram_wr_data;
        if (ram_rd_en) ram_rd_data <= mem[ram_rd_addr];
    end

    badmark_swap #(.ADDR_W(AW)) i_badmark_swap (
        .clk(clk), .rst(rst), .start(start), .byte_ofs(byte_ofs), .bit_ofs(bit_ofs),
        .aux_wr_en(aux_wr_en), .aux_wr_data(aux_wr_data), .aux_byte(aux_byte),
        .busy(busy), .done(done), .ram_rd_en(ram_rd_en), .ram_rd_addr(ram_rd_addr),
        .ram_rd_data(ram_rd_data), .ram_wr_en(ram_wr_en), .ram_wr_addr(ram_wr_addr),
        .ram_wr_data(ram_wr_data)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic load_aux(input logic [7:0] v);
        @(negedge clk);
        aux_wr_en = 1'b1; aux_wr_data = v;
        @(negedge clk);
        aux_wr_en = 1'b0;
    endtask

    // Run one exchange; optionally inject start and aux load while busy
    task automatic run_op(input logic [AW-1:0] b, input logic [2:0] k,
                          input bit inject, output int lat);
        int cnt;
        @(negedge clk);
        start = 1'b1; byte_ofs = b; bit_ofs = k;
        cnt = 0;
        while (1) begin
            @(negedge clk);
            cnt++;
            start = 1'b0;
            aux_wr_en = 1'b0;
            if (inject && cnt == 2) begin
                start = 1'b1; byte_ofs = AW'(b + 8'd40); bit_ofs = 3'd5;
            end
            if (inject && cnt == 3) begin
                aux_wr_en = 1'b1; aux_wr_data = 8'h5A;
            end
            if (done || cnt > 20) break;
        end
        start = 1'b0; aux_wr_en = 1'b0;
        lat = cnt;
        @(negedge clk);
        check("R11", "busy after done", busy, 0);
    endtask

    // Expected results computed from the 16-bit word view
    task automatic verify(input logic [AW-1:0] b, input logic [2:0] k,
                          input logic [7:0] d0, input logic [7:0] d1,
                          input logic [7:0] a, input logic [7:0] nb_lo,
                          input logic [7:0] nb_hi);
        logic [15:0] w, m, nw;
        logic [AW-1:0] b1;
        b1 = AW'(b + 1);
        w  = {d1, d0};
        m  = 16'h00FF << k;
        nw = (w & ~m) | (16'(a) << k);
        check("R3", "aux after swap", aux_byte, 8'((w >> k) & 16'h00FF));
        check("R4", "data[b]", mem[b], nw[7:0]);
        check("R5", "data[b+1]", mem[b1], nw[15:8]);
        check("R8", "byte below b", mem[AW'(b - 1)], nb_lo);
        check("R8", "byte above b+1", mem[AW'(b + 2)], nb_hi);
    endtask

    initial begin
        int lat;
        logic [7:0] d0, d1, a, nlo, nhi;
        logic [AW-1:0] b;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 13 + 7);
        repeat (3) @(negedge clk);
        // R1
        check("R1", "busy in reset", busy, 0);
        check("R1", "done in reset", done, 0);
        check("R1", "rd_en in reset", ram_rd_en, 0);
        check("R1", "wr_en in reset", ram_wr_en, 0);
        check("R1", "aux in reset", aux_byte, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "aux after reset", aux_byte, 0);
        check("R1", "busy after reset", busy, 0);

        // R2
        load_aux(8'hC3);
        check("R2", "aux load", aux_byte, 8'hC3);

        // Sweep every bit position against several patterns (R3 R4 R5 R7 R8)
        for (int p = 0; p < 4; p++) begin
            for (int k = 0; k < 8; k++) begin
                b  = AW'(10 + 30 * p + k);
                d0 = 8'(p * 37 + k * 11 + 5);
                d1 = 8'(p * 91 + k * 23 + 200);
                if (p == 3) begin d0 = 8'hFF; d1 = 8'h00; end
                a  = 8'(k * 29 + p * 71 + 3);
                mem[b] = d0; mem[AW'(b + 1)] = d1;
                nlo = mem[AW'(b - 1)]; nhi = mem[AW'(b + 2)];
                load_aux(a);
                run_op(b, 3'(k), 1'b0, lat);
                check("R7", "latency", lat, 6);
                verify(b, 3'(k), d0, d1, a, nlo, nhi);
                if (k == 0) check("R5", "k=0 keeps data[b+1]", mem[AW'(b + 1)], d1);
                // R6: second exchange restores
                run_op(b, 3'(k), 1'b0, lat);
                check("R6", "restore data[b]", mem[b], d0);
                check("R6", "restore data[b+1]", mem[AW'(b + 1)], d1);
                check("R6", "restore aux", aux_byte, a);
            end
        end

        // R8: address wrap
        b = AW'(255);
        mem[255] = 8'h96; mem[0] = 8'h3C;
        nlo = mem[254]; nhi = mem[1];
        load_aux(8'hE1);
        run_op(b, 3'd4, 1'b0, lat);
        verify(b, 3'd4, 8'h96, 8'h3C, 8'hE1, nlo, nhi);

        // R9 R10: start and aux load during busy are ignored
        b = AW'(150);
        mem[150] = 8'h12; mem[151] = 8'hF0;
        mem[190] = 8'hA5; mem[191] = 8'h5A;
        nlo = mem[149]; nhi = mem[152];
        load_aux(8'h77);
        run_op(b, 3'd3, 1'b1, lat);
        check("R9", "latency with extra start", lat, 6);
        verify(b, 3'd3, 8'h12, 8'hF0, 8'h77, nlo, nhi);
        check("R9", "second target low", mem[190], 8'hA5);
        check("R9", "second target high", mem[191], 8'h5A);
        repeat (8) begin
            @(negedge clk);
            check("R9", "no queued exchange", busy, 0);
        end
        check("R10", "aux not overwritten", aux_byte, 8'(({8'hF0, 8'h12} >> 3) & 16'hFF));

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule